// File: doc/BRIEF.md
# 8-bit Add/Subtract Unit with Status Flags

This block is the add and subtract slice of an 8-bit microcontroller datapath. Each cycle it may take one 16-bit instruction word and decode it into an operation, a destination register and either a source register or an 8-bit constant. It reads its 32 x 8 register file, forms the sum or difference, and updates a six-bit status word in the same clock. The status word holds half-carry, sign, overflow, negative, zero and carry. Compare forms only update the flags. The subtract and compare forms that chain the carry let software compare or subtract values wider than one byte: in those forms the zero flag can only be cleared, never set, so a multi-byte result reads as zero only when every byte was zero.

Two side ports serve the rest of the core. A load port writes a register and a flag-load port writes the status word. Both are ignored in any cycle that issues an instruction. A combinational read port returns the contents of any register.

Top module: `alu8_flags_unit`

## Requirements
- R1: While reset is asserted, and until the internally synchronised release, every register reads 0x00 and the status word reads 0. The status word bits are [5]=H, [4]=S, [3]=V, [2]=N, [1]=Z, [0]=C.
- R2: The register-register forms take the destination index from instr[8:4] and the source index from {instr[9], instr[3:0]}. instr[15:10] selects the form: 000001 compare-with-carry, 000010 subtract-with-carry, 000011 add, 000101 compare, 000110 subtract, 000111 add-with-carry.
- R3: The immediate forms take the destination index 16 + instr[7:4] and the constant {instr[11:8], instr[3:0]}. instr[15:12] selects the form: 0011 compare, 0100 subtract-with-carry, 0101 subtract.
- R4: Add writes (D+S) mod 256, and add-with-carry writes (D+S+C) mod 256. C is the carry out of bit 7 and H is the carry out of bit 3, with the incoming carry counted.
- R5: Subtract forms compute D-S, and the carry forms compute D-S-C. C is the borrow out of bit 7 (the unsigned operand plus carry exceeds D), and H is the borrow out of bit 3.
- R6: V is set when the two's-complement result overflows 8 bits. N equals result bit 7 and S equals N xor V, for every form.
- R7: Add, add-with-carry, subtract, compare and the non-carry immediate forms set Z exactly when the 8-bit result is zero.
- R8: Subtract-with-carry, subtract-immediate-with-carry and compare-with-carry clear Z on a nonzero result and keep the previous Z on a zero result.
- R9: Compare forms update the flags and leave every register unchanged.
- R10: An issued instruction word that matches none of the nine forms changes neither the registers nor the flags.
- R11: An instruction completes in one clock: the register write and the flag update land on the same rising edge. A register load requested in the same cycle as an issued instruction is ignored.
- R12: When no instruction is issued, the load port writes ld_data into register ld_addr and the flag-load port writes the whole status word, each on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Issue instr this cycle |
| instr | input | 16 | Instruction word |
| ld_en | input | 1 | Register load request |
| ld_addr | input | 5 | Register load index |
| ld_data | input | 8 | Register load value |
| flag_ld_en | input | 1 | Status word load request |
| flag_ld_data | input | 6 | Status word load value |
| rd_addr | input | 5 | Read port index |
| rd_data | output | 8 | Read port data (combinational) |
| flags | output | 6 | Status word {H,S,V,N,Z,C} |

## Verification
The bench goes after the signed-overflow boundaries 0x7F+1 and 0x80-1: a design that took V from the carry would miss both. It runs a two-byte equal compare through compare then compare-with-carry, where a design that recomputed Z in the chained form would wrongly report equality or inequality. It issues add-with-carry and subtract-with-carry with C set and nibble values on the edge: a half-carry that ignored the incoming carry would disagree with the reference there. It also drives unused opcodes, and register loads in the same cycle as an issue, where a loose decoder would corrupt a register or the flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_SUBI, OP_SBCI, OP_CPI
  } alu_op_e;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } sflags_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic [IW-1:0] instr,
  output logic          op_valid,
  output logic          is_cmp,
  output logic          is_add,
  output logic          use_cin,
  output logic          chained,
  output logic          use_imm,
  output logic [AW-1:0] dst_idx,
  output logic [AW-1:0] src_idx,
  output logic [DW-1:0] imm
);

  localparam int HALF = DW / 2;

  alu_op_e op;

  always_comb begin
    op = OP_NONE;
    unique case (instr[15:12])
      4'b0011: op = OP_CPI;
      4'b0100: op = OP_SBCI;
      4'b0101: op = OP_SUBI;
      4'b0000, 4'b0001: begin
        case (instr[15:10])
          6'b000001: op = OP_CPC;
          6'b000010: op = OP_SBC;
          6'b000011: op = OP_ADD;
          6'b000101: op = OP_CP;
          6'b000110: op = OP_SUB;
          6'b000111: op = OP_ADC;
          default:   op = OP_NONE;
        endcase
      end
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    op_valid = (op != OP_NONE);
    is_cmp   = (op == OP_CP) || (op == OP_CPC) || (op == OP_CPI);
    is_add   = (op == OP_ADD) || (op == OP_ADC);
    chained  = (op == OP_SBC) || (op == OP_SBCI) || (op == OP_CPC);
    use_cin  = chained || (op == OP_ADC);
    use_imm  = (op == OP_CPI) || (op == OP_SBCI) || (op == OP_SUBI);
    imm      = {instr[11:8], instr[HALF-1:0]};
    src_idx  = {instr[9], instr[3:0]};
    if (use_imm) dst_idx = {1'b1, instr[7:4]};
    else         dst_idx = instr[8:4];
  end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          is_add,
  input  logic          use_cin,
  input  logic          chained,
  input  sflags_t       flags_in,
  output logic [DW-1:0] result,
  output sflags_t       flags_out
);

  localparam int HB  = DW / 2 - 1;
  localparam int MSB = DW - 1;

  logic          cin;
  logic [DW:0]   sum;
  logic [HB+1:0] nib_sum;
  logic [DW-1:0] borrow_t;
  logic [DW-1:0] ovf_t;
  logic          res_zero;

  always_comb begin
    cin      = use_cin & flags_in.c;
    sum      = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
    nib_sum  = {1'b0, opa[HB:0]} + {1'b0, opb[HB:0]} + {{(HB+1){1'b0}}, cin};
    if (is_add) result = sum[DW-1:0];
    else        result = opa - opb - {{(DW-1){1'b0}}, cin};
    borrow_t = (~opa & opb) | (opb & result) | (result & ~opa);
    ovf_t    = (opa & ~opb & ~result) | (~opa & opb & result);
    res_zero = (result == '0);

    if (is_add) begin
      flags_out.c = sum[DW];
      flags_out.h = nib_sum[HB+1];
      flags_out.v = (opa[MSB] == opb[MSB]) && (result[MSB] != opa[MSB]);
    end else begin
      flags_out.c = borrow_t[MSB];
      flags_out.h = borrow_t[HB];
      flags_out.v = ovf_t[MSB];
    end
    flags_out.n = result[MSB];
    flags_out.s = flags_out.n ^ flags_out.v;
    if (chained) flags_out.z = flags_in.z & res_zero;
    else         flags_out.z = res_zero;
  end

endmodule

// File: rtl/alu8_regfile.sv
module alu8_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] rd_c
);

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic wen;
    assign wen = we && (waddr == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[gi] <= '0;
      else if (wen) mem_q[gi] <= wdata;
    end
  end

  assign rd_a = mem_q[ra_a];
  assign rd_b = mem_q[ra_b];
  assign rd_c = mem_q[ra_c];

endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int IW    = 16,
  parameter int FW    = 6,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [IW-1:0] instr,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          flag_ld_en,
  input  logic [FW-1:0] flag_ld_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [FW-1:0] flags
);

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic          op_valid, is_cmp, is_add, use_cin, chained, use_imm;
  logic [AW-1:0] dst_idx, src_idx;
  logic [DW-1:0] imm, dval, sval, opb, alu_res;
  logic          exec_go;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;
  sflags_t       flags_q, flags_d, alu_flags;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  alu8_decode #(.IW(IW), .AW(AW), .DW(DW)) u_dec (
    .instr(instr), .op_valid(op_valid), .is_cmp(is_cmp), .is_add(is_add),
    .use_cin(use_cin), .chained(chained), .use_imm(use_imm),
    .dst_idx(dst_idx), .src_idx(src_idx), .imm(imm)
  );

  alu8_regfile #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_sync_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_a(dst_idx), .ra_b(src_idx), .ra_c(rd_addr),
    .rd_a(dval), .rd_b(sval), .rd_c(rd_data)
  );

  assign opb = use_imm ? imm : sval;

  alu8_arith #(.DW(DW)) u_alu (
    .opa(dval), .opb(opb), .is_add(is_add), .use_cin(use_cin), .chained(chained),
    .flags_in(flags_q), .result(alu_res), .flags_out(alu_flags)
  );

  // write-back select: an issued instruction owns the cycle
  always_comb begin
    exec_go  = exec_en && op_valid;
    rf_we    = 1'b0;
    rf_waddr = ld_addr;
    rf_wdata = ld_data;
    if (exec_en) begin
      rf_we    = exec_go && !is_cmp;
      rf_waddr = dst_idx;
      rf_wdata = alu_res;
    end else if (ld_en) begin
      rf_we    = 1'b1;
    end
  end

  always_comb begin
    flags_d = flags_q;
    if (exec_go)                      flags_d = alu_flags;
    else if (!exec_en && flag_ld_en)  flags_d = sflags_t'(flag_ld_data);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_en,
  input logic          op_valid,
  input logic          is_cmp,
  input logic          chained,
  input logic          rf_we,
  input logic [FW-1:0] flags
);

  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && is_cmp) |-> !rf_we);

  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_valid) |=> (flags[4] == (flags[2] ^ flags[3])));

  // R8
  chain_zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_valid && chained && !flags[1]) |=> !flags[1]);

  // R10
  bad_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !op_valid) |=> $stable(flags));

  // R10
  bad_op_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !op_valid) |-> !rf_we);

endmodule

bind alu8_flags_unit alu8_flags_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .exec_en(exec_en), .op_valid(op_valid),
  .is_cmp(is_cmp), .chained(chained), .rf_we(rf_we), .flags(flags)
);

// File: tb/test_alu8_flags_unit.sv
module test_alu8_flags_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en, ld_en, flag_ld_en;
  logic [15:0] instr;
  logic [4:0]  ld_addr, rd_addr;
  logic [7:0]  ld_data, rd_data;
  logic [5:0]  flag_ld_data, flags;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mreg [32];
  logic [5:0] mflg;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags_unit i_alu8_flags_unit (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .flag_ld_en(flag_ld_en), .flag_ld_data(flag_ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flags(flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // reference model: returns valid, compare, destination, result, new flags
  task automatic model(input logic [15:0] ins, output bit ok, output bit cmp,
                       output logic [4:0] dst, output logic [7:0] res, output logic [5:0] nf);
    int d, k, ci, full, sd, sk, sr;
    bit add, chain, useci, h, c, v, z, n;
    ok = 1; cmp = 0; add = 0; chain = 0; useci = 0;
    if (ins[15:12] inside {4'b0011, 4'b0100, 4'b0101}) begin
      dst = 5'd16 + 5'(ins[7:4]);
      k   = {ins[11:8], ins[3:0]};
      cmp   = (ins[15:12] == 4'b0011);
      chain = (ins[15:12] == 4'b0100);
    end else begin
      dst = ins[8:4];
      k   = mreg[{ins[9], ins[3:0]}];
      case (ins[15:10])
        6'b000001: begin cmp = 1; chain = 1; end
        6'b000010: chain = 1;
        6'b000011: add = 1;
        6'b000101: cmp = 1;
        6'b000110: ;
        6'b000111: begin add = 1; useci = 1; end
        default: ok = 0;
      endcase
    end
    useci = useci | chain;
    d  = mreg[dst];
    ci = useci ? int'(mflg[0]) : 0;
    sd = (d > 127) ? d - 256 : d;
    sk = (k > 127) ? k - 256 : k;
    if (add) begin
      full = d + k + ci;
      c = full > 255;
      h = ((d % 16) + (k % 16) + ci) > 15;
      sr = sd + sk + ci;
    end else begin
      full = d - k - ci;
      c = d < k + ci;
      h = (d % 16) < (k % 16) + ci;
      sr = sd - sk - ci;
    end
    res = full[7:0];
    v = (sr > 127) || (sr < -128);
    n = res[7];
    z = chain ? (mflg[1] && res == 0) : (res == 0);
    nf = {h, n ^ v, v, n, z, c};
    if (!ok) begin nf = mflg; res = mreg[dst]; end
  endtask

  task automatic do_op(input logic [15:0] ins, input string tag,
                       input bit side_ld = 0, input logic [4:0] sa = 0, input logic [7:0] sv = 0);
    bit ok, cmp;
    logic [4:0] dst;
    logic [7:0] res, got;
    logic [5:0] nf;
    model(ins, ok, cmp, dst, res, nf);
    @(negedge clk);
    instr = ins; exec_en = 1; ld_en = side_ld; ld_addr = sa; ld_data = sv;
    flag_ld_en = side_ld; flag_ld_data = ~mflg;
    @(negedge clk);
    exec_en = 0; ld_en = 0; flag_ld_en = 0;
    if (ok && !cmp) mreg[dst] = res;
    mflg = nf;
    chk({tag, " flags"}, flags, mflg);
    read_reg(dst, got);
    chk({tag, " dest"}, got, mreg[dst]);
    if (side_ld) begin
      read_reg(sa, got);
      chk("R11 load ignored during issue", got, mreg[sa]);
    end
  endtask

  task automatic load_reg(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk);
    ld_en = 1; ld_addr = a; ld_data = v;
    @(negedge clk);
    ld_en = 0;
    mreg[a] = v;
  endtask

  task automatic load_flags(input logic [5:0] f);
    @(negedge clk);
    flag_ld_en = 1; flag_ld_data = f;
    @(negedge clk);
    flag_ld_en = 0;
    mflg = f;
  endtask

  function automatic logic [15:0] rr(input logic [5:0] opc, input logic [4:0] d, input logic [4:0] s);
    return {opc, s[4], d, s[3:0]};
  endfunction

  function automatic logic [15:0] ri(input logic [3:0] opc, input logic [3:0] d, input logic [7:0] k);
    return {opc, k[7:4], d, k[3:0]};
  endfunction

  function automatic string tag_of(input logic [15:0] ins);
    if (ins[15:12] == 4'b0011 || ins[15:10] == 6'b000001 || ins[15:10] == 6'b000101) return "R9";
    if (ins[15:12] == 4'b0100 || ins[15:10] == 6'b000010) return "R8";
    if (ins[15:12] == 4'b0101 || ins[15:10] == 6'b000110) return "R5";
    if (ins[15:10] == 6'b000011 || ins[15:10] == 6'b000111) return "R4";
    return "R10";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog expired: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int bad;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 0; exec_en = 0; ld_en = 0; flag_ld_en = 0;
    instr = '0; ld_addr = '0; ld_data = '0; flag_ld_data = '0; rd_addr = '0;
    for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
    mflg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flags in reset", flags, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 flags after release", flags, 0);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      read_reg(5'(i), got);
      if (got != 0) bad++;
    end
    chk("R1 registers cleared", bad, 0);

    // R12 load ports
    load_reg(5'd3, 8'h5A);
    read_reg(5'd3, got);
    chk("R12 register load", got, 8'h5A);
    load_flags(6'b101011);
    chk("R12 flag load", flags, 6'b101011);

    // R2 field placement: destination 17, source 18 (bit 9 set)
    load_reg(5'd17, 8'h10);
    load_reg(5'd18, 8'h22);
    load_flags(6'd0);
    do_op(rr(6'b000011, 5'd17, 5'd18), "R2 add r17,r18");
    read_reg(5'd17, got);
    chk("R2 add result", got, 8'h32);

    // R3 immediate: r20 - 0xA5
    load_reg(5'd20, 8'hF0);
    do_op(ri(4'b0101, 4'd4, 8'hA5), "R3 subi r20");
    read_reg(5'd20, got);
    chk("R3 subi result", got, 8'h4B);

    // R6 overflow corners
    load_reg(5'd1, 8'h7F); load_reg(5'd2, 8'h01);
    do_op(rr(6'b000011, 5'd1, 5'd2), "R6 0x7F+1");
    chk("R6 V on 0x7F+1", flags[3], 1);
    load_reg(5'd1, 8'h80);
    do_op(rr(6'b000110, 5'd1, 5'd2), "R6 0x80-1");
    chk("R6 V on 0x80-1", flags[3], 1);

    // R7 zero and carry: 0xFF + 1
    load_reg(5'd1, 8'hFF);
    do_op(rr(6'b000011, 5'd1, 5'd2), "R7 0xFF+1");
    chk("R7 Z set on zero", flags[1], 1);

    // R4 add-with-carry, carry in on nibble edge
    load_reg(5'd4, 8'h0F); load_reg(5'd5, 8'h00);
    load_flags(6'b000001);
    do_op(rr(6'b000111, 5'd4, 5'd5), "R4 adc H via carry");
    chk("R4 H from carry in", flags[5], 1);

    // R5 subtract-with-carry borrow on nibble edge
    load_reg(5'd6, 8'h10); load_reg(5'd7, 8'h0F);
    load_flags(6'b000001);
    do_op(rr(6'b000010, 5'd6, 5'd7), "R5 sbc");

    // R8 two-byte equal compare: r8:r9 vs r10:r11
    load_reg(5'd8, 8'h34); load_reg(5'd9, 8'h12);
    load_reg(5'd10, 8'h34); load_reg(5'd11, 8'h12);
    do_op(rr(6'b000101, 5'd8, 5'd10), "R9 cp low");
    do_op(rr(6'b000001, 5'd9, 5'd11), "R8 cpc high");
    chk("R8 equal word keeps Z", flags[1], 1);
    // low bytes differ, high equal: Z must stay clear
    load_reg(5'd10, 8'h35);
    do_op(rr(6'b000101, 5'd8, 5'd10), "R9 cp low diff");
    do_op(rr(6'b000001, 5'd9, 5'd11), "R8 cpc high eq");
    chk("R8 zero high byte does not set Z", flags[1], 0);
    do_op(ri(4'b0100, 4'd0, 8'h00), "R8 sbci");

    // R10 unused codes
    do_op(16'hF123, "R10 unused 1111");
    do_op(16'h0345, "R10 unused 000000");
    do_op(16'h1367, "R10 unused 000100");

    // R11 load during issue is ignored
    do_op(rr(6'b000011, 5'd12, 5'd13), "R11 add with side load", 1, 5'd30, 8'hAA);

    // random mix
    for (int t = 0; t < 600; t++) begin
      logic [15:0] ins;
      int kind;
      kind = $urandom_range(0, 10);
      case (kind)
        0: ins = ri(4'b0011, 4'($urandom), 8'($urandom));
        1: ins = ri(4'b0100, 4'($urandom), 8'($urandom));
        2: ins = ri(4'b0101, 4'($urandom), 8'($urandom));
        3: ins = rr(6'b000001, 5'($urandom), 5'($urandom));
        4: ins = rr(6'b000010, 5'($urandom), 5'($urandom));
        5: ins = rr(6'b000011, 5'($urandom), 5'($urandom));
        6: ins = rr(6'b000101, 5'($urandom), 5'($urandom));
        7: ins = rr(6'b000110, 5'($urandom), 5'($urandom));
        8: ins = rr(6'b000111, 5'($urandom), 5'($urandom));
        9: ins = {4'b1111, 12'($urandom)};
        default: begin
          load_reg(5'($urandom), 8'($urandom));
          continue;
        end
      endcase
      do_op(ins, tag_of(ins));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule